// File: doc/BRIEF.md
# Data Address Generation Unit

This unit forms the 16-bit data-memory address used by the memory-operand addressing modes of an 8-bit core, and the write-back value for modes that update an index register. A 3-bit mode code selects the arithmetic. Four 16-bit index registers come in as separate low and high byte vectors, and an index select picks one of them. An 8-bit field carries either an offset or a direct address, and the r3 register value is supplied for the register-offset mode.

All outputs are registered. Each output value reflects the inputs sampled at the previous rising clock edge. The read strobe marks cycles that need a data read. The write-back enable, select and value tell the register file to overwrite an index pair. Modes that take their operand from a register or from the instruction word produce no access. Only one operand per instruction comes from memory. The other operand is always the destination register, so the unit generates at most one address per cycle.

Top module: `dagu_top`

## Requirements
- R1: While `rst_n` is low, and after the first rising edge in reset, every output is zero.
- R2: Mode 2 (direct) gives address {8'h00, offset}, read strobe 1 and write-back enable 0.
- R3: Mode 3 (indexed) gives address index + offset, read strobe 1 and write-back enable 0, and leaves the index unchanged.
- R4: Mode 4 (register offset) gives address index + r3, read strobe 1 and write-back enable 0.
- R5: Mode 5 (post-increment) gives address equal to the unmodified index, read strobe 1, write-back enable 1 and write-back value index + offset.
- R6: Mode 6 (pre-decrement) gives address index - offset, read strobe 1, write-back enable 1, and a write-back value equal to that address.
- R7: Modes 0 (register), 1 (immediate) and 7 (reserved) hold the read strobe and write-back enable at 0, and drive address and write-back value to 0.
- R8: Offsets and r3 are zero-extended to 16 bits, and all address arithmetic wraps modulo 65536.
- R9: The selected index is {high byte, low byte} of pair `idx_sel`, where pair n occupies bits [8n+7:8n] of each byte vector. When write-back is enabled, `wb_sel` equals the sampled `idx_sel`; otherwise it is 0.
- R10: Outputs change one rising edge after their inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Addressing mode code |
| idx_sel_i | input | 2 | Index register select |
| idx_lo_i | input | 32 | Low bytes of the four index pairs |
| idx_hi_i | input | 32 | High bytes of the four index pairs |
| offset_i | input | 8 | Offset or direct address |
| r3_i | input | 8 | r3 register value |
| addr_o | output | 16 | Data address |
| rd_o | output | 1 | Read strobe |
| wb_en_o | output | 1 | Index write-back enable |
| wb_sel_o | output | 2 | Index write-back select |
| wb_val_o | output | 16 | New index value |

## Verification
The bench builds the unit with its default parameters: 8-bit bytes, 16-bit addresses and four index pairs. With these values every pair select is reachable and every mode code, including the reserved one, can be driven. Random offsets and index values near 16'hFFFF and 16'h0000 make both wrap directions likely in the increment and decrement modes. Directed cases pin those wraps and the largest direct address exactly.

// File: rtl/dagu_pkg.sv
// Package: shared mode encoding for the data address generation unit.
// Assumes a 3-bit mode field from instruction decode.
package dagu_pkg;
    typedef enum logic [2:0] {
        AM_REG  = 3'd0,
        AM_IMM  = 3'd1,
        AM_DIR  = 3'd2,
        AM_IDX  = 3'd3,
        AM_IDXR = 3'd4,
        AM_POST = 3'd5,
        AM_PRE  = 3'd6,
        AM_RSVD = 3'd7
    } amode_e;
endpackage

// File: rtl/dagu_idx_pick.sv
// Module: joins each low/high byte pair into a full index and selects one.
// Assumes NUM_IDX is a power of two so every select value names a pair.
module dagu_idx_pick #(
    parameter int DATA_W  = 8,
    parameter int NUM_IDX = 4,
    localparam int SEL_W  = $clog2(NUM_IDX),
    localparam int IDX_W  = 2 * DATA_W
) (
    input  logic [NUM_IDX*DATA_W-1:0] lo_flat,
    input  logic [NUM_IDX*DATA_W-1:0] hi_flat,
    input  logic [SEL_W-1:0]          sel,
    output logic [IDX_W-1:0]          idx
);
    logic [IDX_W-1:0] pairs [NUM_IDX];

    // Concatenate each high byte above its matching low byte.
    for (genvar g = 0; g < NUM_IDX; g++) begin : g_pair
        assign pairs[g] = {hi_flat[g*DATA_W +: DATA_W], lo_flat[g*DATA_W +: DATA_W]};
    end

    // Select the addressed pair.
    assign idx = pairs[sel];
endmodule

// File: rtl/dagu_addr_calc.sv
// Module: mode-driven address and write-back arithmetic, purely combinational.
// Assumes offsets are unsigned and that sums wrap at the address width.
module dagu_addr_calc
    import dagu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W,
    localparam int EXT_W  = ADDR_W - DATA_W
) (
    input  amode_e             mode,
    input  logic [ADDR_W-1:0]  idx,
    input  logic [DATA_W-1:0]  offset,
    input  logic [DATA_W-1:0]  r3,
    output logic [ADDR_W-1:0]  addr,
    output logic               rd,
    output logic               wb,
    output logic [ADDR_W-1:0]  wb_val
);
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] r3_ext;
    logic [ADDR_W-1:0] sum_off;
    logic [ADDR_W-1:0] sum_r3;
    logic [ADDR_W-1:0] dif_off;

    // Zero-extend the byte operands to address width.
    assign off_ext = {{EXT_W{1'b0}}, offset};
    assign r3_ext  = {{EXT_W{1'b0}}, r3};

    // Shared adders; results wrap naturally at ADDR_W bits.
    assign sum_off = idx + off_ext;
    assign sum_r3  = idx + r3_ext;
    assign dif_off = idx - off_ext;

    // Pick address, strobe and write-back per mode.
    always_comb begin
        addr   = '0;
        rd     = 1'b0;
        wb     = 1'b0;
        wb_val = '0;
        case (mode)
            AM_DIR: begin
                addr = off_ext;
                rd   = 1'b1;
            end
            AM_IDX: begin
                addr = sum_off;
                rd   = 1'b1;
            end
            AM_IDXR: begin
                addr = sum_r3;
                rd   = 1'b1;
            end
            AM_POST: begin
                addr   = idx;
                rd     = 1'b1;
                wb     = 1'b1;
                wb_val = sum_off;
            end
            AM_PRE: begin
                addr   = dif_off;
                rd     = 1'b1;
                wb     = 1'b1;
                wb_val = dif_off;
            end
            default: begin
                addr   = '0;
                rd     = 1'b0;
                wb     = 1'b0;
                wb_val = '0;
            end
        endcase
    end
endmodule

// File: rtl/dagu_out_reg.sv
// Module: output register stage with synchronous active-low reset.
// Assumes the select is cleared when no write-back is requested.
module dagu_out_reg #(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic              rd_d,
    input  logic              wb_d,
    input  logic [SEL_W-1:0]  sel_d,
    input  logic [ADDR_W-1:0] wbv_d,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rd_q,
    output logic              wb_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic [ADDR_W-1:0] wbv_q
);
    // Capture the computed access, or clear everything in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rd_q   <= 1'b0;
            wb_q   <= 1'b0;
            sel_q  <= '0;
            wbv_q  <= '0;
        end else begin
            addr_q <= addr_d;
            rd_q   <= rd_d;
            wb_q   <= wb_d;
            sel_q  <= wb_d ? sel_d : '0;
            wbv_q  <= wbv_d;
        end
    end
endmodule

// File: rtl/dagu_top.sv
// Module: data address generation unit top. Selects an index pair,
// computes the address for the requested mode and registers the result.
// Assumes one memory operand per instruction and NUM_IDX a power of two.
module dagu_top
    import dagu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_IDX = 4,
    localparam int SEL_W  = $clog2(NUM_IDX),
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                mode_i,
    input  logic [SEL_W-1:0]          idx_sel_i,
    input  logic [NUM_IDX*DATA_W-1:0] idx_lo_i,
    input  logic [NUM_IDX*DATA_W-1:0] idx_hi_i,
    input  logic [DATA_W-1:0]         offset_i,
    input  logic [DATA_W-1:0]         r3_i,
    output logic [ADDR_W-1:0]         addr_o,
    output logic                      rd_o,
    output logic                      wb_en_o,
    output logic [SEL_W-1:0]          wb_sel_o,
    output logic [ADDR_W-1:0]         wb_val_o
);
    logic [ADDR_W-1:0] idx_cur;
    logic [ADDR_W-1:0] addr_c;
    logic [ADDR_W-1:0] wbv_c;
    logic              rd_c;
    logic              wb_c;
    amode_e            mode_c;

    // Map the raw mode bits onto the shared encoding.
    assign mode_c = amode_e'(mode_i);

    dagu_idx_pick #(.DATA_W(DATA_W), .NUM_IDX(NUM_IDX)) u_pick (
        .lo_flat (idx_lo_i),
        .hi_flat (idx_hi_i),
        .sel     (idx_sel_i),
        .idx     (idx_cur)
    );

    dagu_addr_calc #(.DATA_W(DATA_W)) u_calc (
        .mode    (mode_c),
        .idx     (idx_cur),
        .offset  (offset_i),
        .r3      (r3_i),
        .addr    (addr_c),
        .rd      (rd_c),
        .wb      (wb_c),
        .wb_val  (wbv_c)
    );

    dagu_out_reg #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_oreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_d  (addr_c),
        .rd_d    (rd_c),
        .wb_d    (wb_c),
        .sel_d   (idx_sel_i),
        .wbv_d   (wbv_c),
        .addr_q  (addr_o),
        .rd_q    (rd_o),
        .wb_q    (wb_en_o),
        .sel_q   (wb_sel_o),
        .wbv_q   (wb_val_o)
    );
endmodule

// File: rtl/dagu_chk.sv
// Module: property checker for dagu_top, attached by bind below.
// Assumes default-style parameters passed through from the top.
module dagu_chk #(
    parameter int DATA_W  = 8,
    parameter int NUM_IDX = 4,
    localparam int SEL_W  = $clog2(NUM_IDX),
    localparam int ADDR_W = 2 * DATA_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [2:0]                mode_i,
    input logic [SEL_W-1:0]          idx_sel_i,
    input logic [NUM_IDX*DATA_W-1:0] idx_lo_i,
    input logic [NUM_IDX*DATA_W-1:0] idx_hi_i,
    input logic [DATA_W-1:0]         offset_i,
    input logic [DATA_W-1:0]         r3_i,
    input logic [ADDR_W-1:0]         addr_o,
    input logic                      rd_o,
    input logic                      wb_en_o,
    input logic [SEL_W-1:0]          wb_sel_o,
    input logic [ADDR_W-1:0]         wb_val_o
);
    logic [ADDR_W-1:0] off_x;

    // Zero-extended offset seen by the checker.
    assign off_x = {{(ADDR_W-DATA_W){1'b0}}, offset_i};

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (addr_o == '0 && !rd_o && !wb_en_o && wb_val_o == '0)); // R1
    AST_DIRECT_PAGE: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(mode_i) == 3'd2) |-> (addr_o == $past(off_x) && rd_o && !wb_en_o)); // R2
    AST_INDEXED_NO_WB: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(mode_i) == 3'd3) |-> (rd_o && !wb_en_o)); // R3
    AST_REGOFF_NO_WB: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(mode_i) == 3'd4) |-> (rd_o && !wb_en_o)); // R4
    AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(mode_i) == 3'd5) |-> (wb_en_o && rd_o && wb_val_o == addr_o + $past(off_x))); // R5
    AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $past(mode_i) == 3'd6) |-> (wb_en_o && rd_o && wb_val_o == addr_o)); // R6
    AST_IDLE_MODES: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && ($past(mode_i) <= 3'd1 || $past(mode_i) == 3'd7)) |-> (!rd_o && !wb_en_o && addr_o == '0)); // R7
    AST_WB_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n) wb_en_o |-> rd_o); // R5
    AST_WB_SELECT: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && wb_en_o) |-> (wb_sel_o == $past(idx_sel_i))); // R9
endmodule

bind dagu_top dagu_chk #(.DATA_W(DATA_W), .NUM_IDX(NUM_IDX)) u_chk (.*);

// File: tb/dagu_top_tb.sv
module dagu_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [1:0]  idx_sel_i = '0;
    logic [31:0] idx_lo_i = '0;
    logic [31:0] idx_hi_i = '0;
    logic [7:0]  offset_i = '0;
    logic [7:0]  r3_i = '0;
    logic [15:0] addr_o;
    logic        rd_o;
    logic        wb_en_o;
    logic [1:0]  wb_sel_o;
    logic [15:0] wb_val_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dagu_top u_dut (.*);

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Expected outputs: {addr, rd, wb, sel, wbval} packed into 36 bits.
    function automatic logic [35:0] model(input logic [2:0] m, input logic [1:0] s,
                                          input logic [31:0] lo, input logic [31:0] hi,
                                          input logic [7:0] off, input logic [7:0] r3v);
        logic [15:0] ix;
        logic [15:0] oe;
        ix = {hi[s*8 +: 8], lo[s*8 +: 8]};
        oe = {8'h00, off};
        case (m)
            3'd2: return {oe, 1'b1, 1'b0, 2'd0, 16'h0};
            3'd3: return {16'(ix + oe), 1'b1, 1'b0, 2'd0, 16'h0};
            3'd4: return {16'(ix + {8'h00, r3v}), 1'b1, 1'b0, 2'd0, 16'h0};
            3'd5: return {ix, 1'b1, 1'b1, s, 16'(ix + oe)};
            3'd6: return {16'(ix - oe), 1'b1, 1'b1, s, 16'(ix - oe)};
            default: return 36'h0;
        endcase
    endfunction

    task automatic cmp(input logic [35:0] exp, input string tag);
        logic [35:0] act;
        act = {addr_o, rd_o, wb_en_o, wb_sel_o, wb_val_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at falling edge, check after the next rising edge (R10).
    task automatic run(input logic [2:0] m, input logic [1:0] s, input logic [15:0] ix,
                       input logic [7:0] off, input logic [7:0] r3v, input string extra);
        logic [35:0] exp;
        mode_i = m;
        idx_sel_i = s;
        idx_lo_i[s*8 +: 8] = ix[7:0];
        idx_hi_i[s*8 +: 8] = ix[15:8];
        offset_i = off;
        r3_i = r3v;
        exp = model(m, s, idx_lo_i, idx_hi_i, off, r3v);
        @(posedge clk);
        @(negedge clk);
        cmp(exp, {tag_of(m), extra});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] base;
        void'($urandom(32'd7731));
        mode_i = 3'd5;
        offset_i = 8'h11;
        idx_lo_i = 32'h44332211;
        idx_hi_i = 32'h88776655;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp(36'h0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R10: inputs sampled at the first edge out of reset show up now.
        cmp(model(3'd5, 2'd0, idx_lo_i, idx_hi_i, 8'h11, 8'h00), "R10 latency");
        // Directed corner cases.
        run(3'd2, 2'd1, 16'h1234, 8'hFF, 8'h00, " direct top byte");
        run(3'd3, 2'd2, 16'hABCD, 8'h00, 8'h00, " indexed zero offset");
        run(3'd3, 2'd3, 16'hFFFF, 8'h01, 8'h00, " R8 indexed wrap");
        run(3'd4, 2'd0, 16'hFFFF, 8'h00, 8'h01, " R8 r3 wrap");
        run(3'd5, 2'd1, 16'hFFF0, 8'h20, 8'h00, " R8 post wrap");
        run(3'd6, 2'd2, 16'h0005, 8'h10, 8'h00, " R8 pre wrap");
        run(3'd6, 2'd3, 16'h8000, 8'h80, 8'h00, " R9 sel3");
        run(3'd0, 2'd1, 16'h1111, 8'h55, 8'h66, " reg mode");
        run(3'd1, 2'd2, 16'h2222, 8'h77, 8'h88, " imm mode");
        run(3'd7, 2'd3, 16'h3333, 8'h99, 8'hAA, " reserved");
        // R9: each pair picked distinctly with others holding other values.
        for (int k = 0; k < 4; k++) begin
            idx_lo_i = $urandom;
            idx_hi_i = $urandom;
            run(3'd5, 2'(k), 16'(16'h1000 * (k + 1) + k), 8'h03, 8'h00, " R9 pair");
        end
        // Constrained random: indices biased toward both ends of the space.
        for (int n = 0; n < 400; n++) begin
            idx_lo_i = $urandom;
            idx_hi_i = $urandom;
            case ($urandom_range(0, 2))
                0: base = 16'hFF00 | 16'($urandom_range(0, 255));
                1: base = 16'($urandom_range(0, 255));
                default: base = 16'($urandom);
            endcase
            run(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), base,
                8'($urandom), 8'($urandom), " random");
        end
        // R1: reset in mid-run clears the outputs again.
        mode_i = 3'd6;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cmp(36'h0, "R1 mid reset");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule